// File: doc/BRIEF.md
# Masked-Write Configuration Register Bank

This block holds a handful of 16-bit control registers behind a plain memory-mapped port. Every 32-bit write word carries its own bit-enable mask in the upper half: a data bit in the lower half is stored only when its partner enable bit is set. Any other bit keeps its old value. Software can therefore change one field without reading the register first.

A second request port updates one named field in a single cycle. The caller gives a field code and a boolean. The block looks up the field's bit range and its on and off values, then builds the masked word for that field. That word goes through the same write path as a bus write. The bank also drives a power-up bit, a low-frequency receive-signalling enable, and a 16-bit configuration word for each of two ports directly as output pins.

Top module: `cfgbank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stored bit is cleared to zero.
- R2: On a bus write (`bus_we`=1) to a mapped offset, stored bit n (0..15) takes `bus_wdata[n]` when `bus_wdata[n+16]` is 1 and keeps its old value when it is 0. The mapped offsets are 0x04, 0x08, 0x10, 0x1C and 0x34.
- R3: `bus_rdata` is combinational from `bus_addr`. For a mapped offset, bits 15:0 carry the stored value and bits 31:16 are zero.
- R4: A bus write to an unmapped offset changes no stored bit, and a read of an unmapped offset returns zero.
- R5: A field request with no bus write in the same cycle writes the chosen value into bits [hi:lo] of the field's register. All other bits of that register and of every other register are left alone.
- R6: `fld_on`=1 selects a field's on value and `fld_on`=0 selects its off value. The codes on `fld_id` are as follows. 0 is offset 0x04 bit 13, with on 1 and off 0. 1 is offset 0x04 bit 14, with on 1 and off 0. 2 is offset 0x1C bits 15:0 and 3 is offset 0x34 bits 15:0; both use on 0x0188 and off 0x1100. 4 is offset 0x08 bits 1:0 and 5 is offset 0x10 bits 3:2; both use on 0x3 and off 0x2.
- R7: When `bus_we` and `fld_req` are both high in one cycle, only the bus write takes effect and the field request is dropped.
- R8: A field request with code 6 or 7 changes no stored bit.
- R9: `phy_pwr_on` is bit 13 of offset 0x04 and `rx_lfps_en` is bit 14 of offset 0x04. `port0_cfg` is offset 0x1C and `port1_cfg` is offset 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Enable mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fld_req | input | 1 | Field update request |
| fld_id | input | 3 | Field code |
| fld_on | input | 1 | Select on value (1) or off value (0) |
| phy_pwr_on | output | 1 | Power-up control bit |
| rx_lfps_en | output | 1 | Low-frequency receive signalling enable |
| port0_cfg | output | 16 | Port 0 configuration word |
| port1_cfg | output | 16 | Port 1 configuration word |

## Verification
The bench starts with directed patterns. An all-ones mask checks that a full overwrite works. Sparse and alternating masks show whether the mask is applied per bit, as opposed to per byte or not at all. An all-zero mask shows that nothing is written when no bit is enabled. Field requests for every code, both on and off, check that each field's range and value are correct. Because two fields share one register, these requests also show whether a field write clobbers its neighbour. Collision cycles separate bus priority from field priority. Unmapped offsets and invalid codes separate a true ignore from a misdecode into some register. A seeded random mix of all these operations is then compared after every step against a bench model of all five registers and all four output pins.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int ADDR_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int ID_W     = 3;
    localparam int PWR_BIT  = 13;
    localparam int LFPS_BIT = 14;
    localparam int IDX_PWR  = 0;
    localparam int IDX_P0   = 3;
    localparam int IDX_P1   = 4;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ID_W-1:0] {
        FLD_PWR   = 3'd0,
        FLD_LFPS  = 3'd1,
        FLD_PORT0 = 3'd2,
        FLD_PORT1 = 3'd3,
        FLD_SESSA = 3'd4,
        FLD_SESSB = 3'd5
    } fld_id_e;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic [4:0] hi;
        logic [4:0] lo;
        half_t on_val;
        half_t off_val;
    } fld_desc_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        word_t word;
    } wr_req_t;

    function automatic addr_t reg_offset(input int idx);
        case (idx)
            0:       return 8'h04;
            1:       return 8'h08;
            2:       return 8'h10;
            3:       return 8'h1c;
            default: return 8'h34;
        endcase
    endfunction

    function automatic fld_desc_t fld_lookup(input logic [ID_W-1:0] id);
        fld_desc_t d;
        d = '0;
        d.valid = 1'b1;
        case (id)
            FLD_PWR:   begin d.addr = 8'h04; d.hi = 5'd13; d.lo = 5'd13; d.on_val = 16'h1;    d.off_val = 16'h0;    end
            FLD_LFPS:  begin d.addr = 8'h04; d.hi = 5'd14; d.lo = 5'd14; d.on_val = 16'h1;    d.off_val = 16'h0;    end
            FLD_PORT0: begin d.addr = 8'h1c; d.hi = 5'd15; d.lo = 5'd0;  d.on_val = 16'h0188; d.off_val = 16'h1100; end
            FLD_PORT1: begin d.addr = 8'h34; d.hi = 5'd15; d.lo = 5'd0;  d.on_val = 16'h0188; d.off_val = 16'h1100; end
            FLD_SESSA: begin d.addr = 8'h08; d.hi = 5'd1;  d.lo = 5'd0;  d.on_val = 16'h3;    d.off_val = 16'h2;    end
            FLD_SESSB: begin d.addr = 8'h10; d.hi = 5'd3;  d.lo = 5'd2;  d.on_val = 16'h3;    d.off_val = 16'h2;    end
            default:   d.valid = 1'b0;
        endcase
        return d;
    endfunction

    function automatic word_t field_word(input logic [4:0] hi, input logic [4:0] lo,
                                         input half_t val);
        half_t m;
        for (int i = 0; i < HALF_W; i++)
            m[i] = (i >= int'(lo)) && (i <= int'(hi));
        return {m, half_t'(val << lo)};
    endfunction

    function automatic half_t masked_merge(input half_t old, input word_t w);
        return (old & ~w[WORD_W-1:HALF_W]) | (w[HALF_W-1:0] & w[WORD_W-1:HALF_W]);
    endfunction

endpackage

// File: rtl/cfgbank_fld_enc.sv
module cfgbank_fld_enc
    import cfgbank_pkg::*;
(
    input  logic            fld_req,
    input  logic [ID_W-1:0] fld_id,
    input  logic            fld_on,
    output wr_req_t         fld_wr
);
    fld_desc_t desc;

    always_comb begin
        desc          = fld_lookup(fld_id);
        fld_wr.valid  = fld_req && desc.valid;
        fld_wr.addr   = desc.addr;
        fld_wr.word   = field_word(desc.hi, desc.lo, fld_on ? desc.on_val : desc.off_val);
    end
endmodule

// File: rtl/cfgbank_slot.sv
module cfgbank_slot
    import cfgbank_pkg::*;
#(
    parameter addr_t OFFSET = 8'h04
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    output half_t   q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr.valid && wr.addr == OFFSET)
            q <= masked_merge(q, wr.word);
    end
endmodule

// File: rtl/cfgbank.sv
module cfgbank
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              fld_req,
    input  logic [ID_W-1:0]   fld_id,
    input  logic              fld_on,
    output logic              phy_pwr_on,
    output logic              rx_lfps_en,
    output logic [HALF_W-1:0] port0_cfg,
    output logic [HALF_W-1:0] port1_cfg
);
    wr_req_t fld_wr;
    wr_req_t wr_sel;
    half_t   regs [NUM_REGS];

    cfgbank_fld_enc u_enc (
        .fld_req (fld_req),
        .fld_id  (fld_id),
        .fld_on  (fld_on),
        .fld_wr  (fld_wr)
    );

    // bus write wins over a field request in the same cycle
    always_comb begin
        if (bus_we) begin
            wr_sel.valid = 1'b1;
            wr_sel.addr  = bus_addr;
            wr_sel.word  = bus_wdata;
        end else begin
            wr_sel = fld_wr;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        cfgbank_slot #(.OFFSET(reg_offset(g))) u_slot (
            .clk (clk),
            .rst (rst),
            .wr  (wr_sel),
            .q   (regs[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (bus_addr == reg_offset(i))
                bus_rdata = {{HALF_W{1'b0}}, regs[i]};
    end

    assign phy_pwr_on = regs[IDX_PWR][PWR_BIT];
    assign rx_lfps_en = regs[IDX_PWR][LFPS_BIT];
    assign port0_cfg  = regs[IDX_P0];
    assign port1_cfg  = regs[IDX_P1];
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        fld_req,
    input logic [2:0]  fld_id,
    input logic        fld_on,
    input logic        phy_pwr_on,
    input logic        rx_lfps_en,
    input logic [15:0] port0_cfg,
    input logic [15:0] port1_cfg
);
    logic mapped;
    assign mapped = (bus_addr == 8'h04) || (bus_addr == 8'h08) || (bus_addr == 8'h10)
                 || (bus_addr == 8'h1c) || (bus_addr == 8'h34);

    AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h1c && bus_wdata[31:16] == 16'h0) |=> $stable(port0_cfg)); // R2

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == 16'h0); // R3

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == 32'h0); // R4

    AST_PWR_FIELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && fld_req && fld_id == 3'd0) |=> (phy_pwr_on == $past(fld_on)) && $stable(rx_lfps_en)); // R5

    AST_PORT0_ON: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && fld_req && fld_id == 3'd2 && fld_on) |=> port0_cfg == 16'h0188); // R6

    AST_BUS_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr != 8'h34 && fld_req && fld_id == 3'd3) |=> $stable(port1_cfg)); // R7

    AST_BAD_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && fld_req && fld_id > 3'd5) |=> $stable(port0_cfg) && $stable(port1_cfg)
            && $stable(phy_pwr_on) && $stable(rx_lfps_en)); // R8
endmodule

bind cfgbank cfgbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .fld_req    (fld_req),
    .fld_id     (fld_id),
    .fld_on     (fld_on),
    .phy_pwr_on (phy_pwr_on),
    .rx_lfps_en (rx_lfps_en),
    .port0_cfg  (port0_cfg),
    .port1_cfg  (port1_cfg)
);

// File: tb/cfgbank_tb.sv
module cfgbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        fld_req;
    logic [2:0]  fld_id;
    logic        fld_on;
    logic        phy_pwr_on;
    logic        rx_lfps_en;
    logic [15:0] port0_cfg;
    logic [15:0] port1_cfg;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgbank u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fld_req(fld_req),
        .fld_id(fld_id), .fld_on(fld_on), .phy_pwr_on(phy_pwr_on),
        .rx_lfps_en(rx_lfps_en), .port0_cfg(port0_cfg), .port1_cfg(port1_cfg)
    );

    function automatic logic [7:0] offs(input int i);
        case (i)
            0: return 8'h04; 1: return 8'h08; 2: return 8'h10; 3: return 8'h1c;
            default: return 8'h34;
        endcase
    endfunction

    function automatic int idx_of(input logic [7:0] a);
        for (int i = 0; i < 5; i++) if (offs(i) == a) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model of a bus write (R2, R4)
    task automatic mdl_bus(input logic [7:0] a, input logic [31:0] w);
        int k;
        k = idx_of(a);
        if (k >= 0)
            for (int b = 0; b < 16; b++) if (w[b+16]) model[k][b] = w[b];
    endtask

    // model of a field request (R5, R6, R8)
    task automatic mdl_fld(input logic [2:0] id, input logic on);
        int k, hi, lo;
        logic [15:0] v;
        case (id)
            3'd0: begin k = 0; hi = 13; lo = 13; v = on ? 16'h1 : 16'h0; end
            3'd1: begin k = 0; hi = 14; lo = 14; v = on ? 16'h1 : 16'h0; end
            3'd2: begin k = 3; hi = 15; lo = 0;  v = on ? 16'h0188 : 16'h1100; end
            3'd3: begin k = 4; hi = 15; lo = 0;  v = on ? 16'h0188 : 16'h1100; end
            3'd4: begin k = 1; hi = 1;  lo = 0;  v = on ? 16'h3 : 16'h2; end
            3'd5: begin k = 2; hi = 3;  lo = 2;  v = on ? 16'h3 : 16'h2; end
            default: begin k = -1; hi = 0; lo = 0; v = 16'h0; end
        endcase
        if (k >= 0)
            for (int b = lo; b <= hi; b++) model[k][b] = v[b-lo];
    endtask

    // called at a negedge: compare every register and pin with the model
    task automatic check_all(input string tag);
        for (int i = 0; i < 5; i++) begin
            bus_addr = offs(i);
            #1;
            check({tag, " R3 read"}, bus_rdata, {16'h0, model[i]});
        end
        check({tag, " R9 pwr"},   {31'h0, phy_pwr_on}, {31'h0, model[0][13]});
        check({tag, " R9 lfps"},  {31'h0, rx_lfps_en}, {31'h0, model[0][14]});
        check({tag, " R9 port0"}, {16'h0, port0_cfg},  {16'h0, model[3]});
        check({tag, " R9 port1"}, {16'h0, port1_cfg},  {16'h0, model[4]});
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] w,
                        input logic fr, input logic [2:0] id, input logic on);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = w; fld_req = fr; fld_id = id; fld_on = on;
        if (we) mdl_bus(a, w);
        else if (fr) mdl_fld(id, on);
        @(negedge clk);
        bus_we = 1'b0; fld_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        rst = 1'b1; bus_we = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
        fld_req = 1'b0; fld_id = 3'd0; fld_on = 1'b0;
        for (int i = 0; i < 5; i++) model[i] = 16'h0;
        // dirty the registers, then check reset clears them (R1)
        repeat (2) @(negedge clk);
        rst = 1'b0;
        step(1'b1, 8'h1c, 32'hffff_5a5a, 1'b0, 3'd0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 5; i++) model[i] = 16'h0;
        check_all("R1 reset");

        // R2: full, sparse, zero masks
        step(1'b1, 8'h04, 32'hffff_abcd, 1'b0, 3'd0, 1'b0);
        check_all("R2 full mask");
        step(1'b1, 8'h04, 32'h00f0_0000, 1'b0, 3'd0, 1'b0);
        check_all("R2 nibble clear");
        step(1'b1, 8'h34, 32'haaaa_ffff, 1'b0, 3'd0, 1'b0);
        check_all("R2 alternate mask");
        step(1'b1, 8'h34, 32'h0000_0000, 1'b0, 3'd0, 1'b0);
        check_all("R2 zero mask");

        // R4: unmapped write and read
        step(1'b1, 8'h0c, 32'hffff_ffff, 1'b0, 3'd0, 1'b0);
        check_all("R4 unmapped write");
        bus_addr = 8'h0c; #1;
        check("R4 unmapped read", bus_rdata, 32'h0);
        bus_addr = 8'h05; #1;
        check("R4 unaligned read", bus_rdata, 32'h0);

        // R5, R6: every field on and off
        for (int id = 0; id < 6; id++) begin
            step(1'b0, 8'h00, 32'h0, 1'b1, 3'(id), 1'b1);
            check_all("R6 field on");
            step(1'b0, 8'h00, 32'h0, 1'b1, 3'(id), 1'b0);
            check_all("R5 field off");
        end
        step(1'b1, 8'h04, 32'hffff_ffff, 1'b0, 3'd0, 1'b0);
        step(1'b0, 8'h00, 32'h0, 1'b1, 3'd0, 1'b0);
        check_all("R5 neighbour kept");

        // R7: collision, bus wins
        step(1'b1, 8'h08, 32'hffff_1234, 1'b1, 3'd3, 1'b1);
        check_all("R7 collision");

        // R8: invalid codes
        step(1'b0, 8'h00, 32'h0, 1'b1, 3'd6, 1'b1);
        check_all("R8 code 6");
        step(1'b0, 8'h00, 32'h0, 1'b1, 3'd7, 1'b0);
        check_all("R8 code 7");

        // seeded random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [7:0] a;
            op = $urandom % 3;
            a  = ($urandom % 4 == 0) ? 8'($urandom) : offs($urandom % 5);
            step(op != 1, a, $urandom, op != 0, 3'($urandom), 1'($urandom));
            check_all("R2 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule